// File: doc/BRIEF.md
# Clocked Bidirectional Byte Port

This block controls one 8-bit group of digital I/O lines. The whole group acts either as an output, driving a byte onto the pins, or as an input, sampling the byte on the pins. The host loads a data byte and two configuration bytes through a simple write interface. Data for the pins first lands in a holding buffer. From there it moves into an output latch when the selected clock fires. In transparent mode the buffer drives the pins directly.

The output latch and the input latch each pick their clock from four candidates:
- the port's own front-panel clock;
- a routed trigger line;
- a global trigger;
- a software "immediate" pulse.

Each latch then passes its chosen clock through its own polarity inverter. Flipping the inversion while the selected clock rests low is therefore a real capture edge. Selecting no source makes that latch transparent.

All asynchronous candidates, the direction request and the pin inputs are brought into the system clock through two-flop synchronisers. A capture is a one-cycle enable raised when the polarity-adjusted clock goes from 0 to 1. The readback byte follows the effective direction: the output-side value when driving, the input-side value when receiving.

Top module: `clkd_byte_port`

## Requirements
- R1: While reset is held and right after its release, `pin_oe` is 0 and both `pin_out` and `rd_data` are 0 with the pins at 0. Reset leaves the port as a transparent input with normal polarity and both latches cleared.
- R2: A write to address 1 with bit 0 set makes `pin_oe` 1 in the cycle after the write. Bit 0 clear makes it 0, unless R3 applies.
- R3: `pin_oe` is the OR of the programmed drive bit and `dir_req`. A change on `dir_req` reaches `pin_oe` after the second rising clock edge.
- R4: Source codes live at address 2: bits [2:0] for the output latch, bits [6:4] for the input latch. The codes are 0 none, 1 front-panel clock, 2 trigger input, 3 global trigger, 4 immediate. With output source 0, a byte written to address 0 appears on `pin_out` in the cycle after the write.
- R5: With a clocked output source, writes to address 0 leave `pin_out` at the output latch value until the selected clock rises.
- R6: A one-cycle `sw_trig` pulse captures, at that edge, into every latch whose source is immediate. This covers the output latch taking the buffer and the input latch taking the synchronised pins.
- R7: Address 1 bit 1 inverts the output latch clock and bit 2 inverts the input latch clock. Setting a bit from 0 to 1 while the selected source is low captures into that latch one cycle after the write. With inversion on, a source rise does not capture and a source fall does.
- R8: With input source 0, `rd_data` follows the pins while not driving. A pin change is visible after the second rising edge and not after the first.
- R9: With a clocked input source, later pin changes do not alter `rd_data` until the next selected edge.
- R10: `rd_data` shows the output-side value (buffer if transparent, output latch if clocked) when `pin_oe` is 1. It shows the input-side value when `pin_oe` is 0.
- R11: Activity on a clock candidate that is not selected causes no capture.
- R12: A selected edge on an asynchronous clock candidate updates the latch at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 2 | 0 data buffer, 1 drive/polarity control, 2 clock sources |
| wr_data | input | 8 | Host write byte |
| ext_clk | input | 1 | Port's own front-panel clock (asynchronous) |
| trig_in | input | 1 | Routed trigger line (asynchronous) |
| glb_trig | input | 1 | Global trigger (asynchronous) |
| sw_trig | input | 1 | Software immediate pulse, synchronous, one cycle |
| dir_req | input | 1 | External request to drive the pins (asynchronous) |
| pin_in | input | 8 | Value seen on the pins |
| pin_out | output | 8 | Byte presented to the pin drivers |
| pin_oe | output | 1 | Drive enable for the whole group |
| rd_data | output | 8 | Readback byte |

## Verification
Results have fixed latencies:
- Host writes of data or configuration show on the ports in the cycle after the write edge.
- A software pulse captures on the edge that samples it.
- A polarity flip captures one edge after the write takes effect.
- Pin, direction-request and asynchronous clock changes take two edges to pass the synchronisers. A capture they trigger lands on the third edge.

The bench drives inputs on the falling edge and samples on the falling edge after exactly that many rising edges. Where the latency itself is the requirement, it also samples one edge earlier and expects the old value.

// File: rtl/byteport_pkg.sv
package byteport_pkg;

    localparam int SRC_W = 3;

    localparam logic [SRC_W-1:0] SRC_NONE   = 3'd0;
    localparam logic [SRC_W-1:0] SRC_EXT    = 3'd1;
    localparam logic [SRC_W-1:0] SRC_TRIG   = 3'd2;
    localparam logic [SRC_W-1:0] SRC_GLOBAL = 3'd3;
    localparam logic [SRC_W-1:0] SRC_IMM    = 3'd4;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_SRC  = 2'd2;

    // Bit positions inside the host-visible bytes
    localparam int CTRL_DRIVE   = 0;
    localparam int CTRL_OUT_INV = 1;
    localparam int CTRL_IN_INV  = 2;
    localparam int SRC_OUT_LSB  = 0;
    localparam int SRC_IN_LSB   = 4;

    localparam int NUM_PATHS = 2;
    localparam int PATH_OUT  = 0;
    localparam int PATH_IN   = 1;

    typedef struct packed {
        logic             drive;
        logic             out_inv;
        logic             in_inv;
        logic [SRC_W-1:0] out_src;
        logic [SRC_W-1:0] in_src;
    } port_cfg_t;

endpackage

// File: rtl/byteport_sync.sv
module byteport_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/byteport_clk_sel.sv
module byteport_clk_sel
    import byteport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             inv_i,
    input  logic             ext_s_i,
    input  logic             trig_s_i,
    input  logic             glb_s_i,
    input  logic             imm_i,
    output logic             fire_o,
    output logic             clocked_o
);

    logic sel;
    logic level_d;
    logic level_q;

    always_comb begin
        case (src_i)
            SRC_EXT:    sel = ext_s_i;
            SRC_TRIG:   sel = trig_s_i;
            SRC_GLOBAL: sel = glb_s_i;
            SRC_IMM:    sel = imm_i;
            default:    sel = 1'b0;
        endcase
        clocked_o = (src_i >= SRC_EXT) && (src_i <= SRC_IMM);
        level_d   = sel ^ inv_i;
        fire_o    = clocked_o && level_d && !level_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    // Flipping polarity to invert over a resting-low source is a capture edge
    AST_POL_FLIP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (clocked_o && $stable(src_i) && !sel && !$past(sel) && $rose(inv_i)) |-> fire_o); // R7

endmodule

// File: rtl/clkd_byte_port.sv
module clkd_byte_port
    import byteport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_clk,
    input  logic              trig_in,
    input  logic              glb_trig,
    input  logic              sw_trig,
    input  logic              dir_req,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CTL_SYNC_W = 4;

    typedef struct packed {
        port_cfg_t         cfg;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] out_lat;
        logic [DATA_W-1:0] in_lat;
    } port_state_t;

    port_state_t st_d;
    port_state_t st_q;

    logic [CTL_SYNC_W-1:0] ctl_s;
    logic [DATA_W-1:0]     pin_s;
    logic                  ext_s;
    logic                  trig_s;
    logic                  glb_s;
    logic                  dir_s;

    logic [NUM_PATHS-1:0]  fire;
    logic [NUM_PATHS-1:0]  clocked;
    logic [SRC_W-1:0]      path_src [NUM_PATHS];
    logic                  path_inv [NUM_PATHS];

    logic [DATA_W-1:0]     out_val;
    logic [DATA_W-1:0]     in_val;

    logic                  unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DATA_W-1:SRC_IN_LSB+SRC_W], wr_data[SRC_OUT_LSB+SRC_W]};

    // Synchronisers for asynchronous control lines and the pins
    byteport_sync #(.W(CTL_SYNC_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dir_req, glb_trig, trig_in, ext_clk}),
        .sync_o  (ctl_s)
    );

    byteport_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_s)
    );

    assign ext_s  = ctl_s[0];
    assign trig_s = ctl_s[1];
    assign glb_s  = ctl_s[2];
    assign dir_s  = ctl_s[3];

    assign path_src[PATH_OUT] = st_q.cfg.out_src;
    assign path_src[PATH_IN]  = st_q.cfg.in_src;
    assign path_inv[PATH_OUT] = st_q.cfg.out_inv;
    assign path_inv[PATH_IN]  = st_q.cfg.in_inv;

    // One clock selector per latch
    for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
        byteport_clk_sel u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (path_src[k]),
            .inv_i     (path_inv[k]),
            .ext_s_i   (ext_s),
            .trig_s_i  (trig_s),
            .glb_s_i   (glb_s),
            .imm_i     (sw_trig),
            .fire_o    (fire[k]),
            .clocked_o (clocked[k])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_DATA: st_d.hold = wr_data;
                ADDR_CTRL: begin
                    st_d.cfg.drive   = wr_data[CTRL_DRIVE];
                    st_d.cfg.out_inv = wr_data[CTRL_OUT_INV];
                    st_d.cfg.in_inv  = wr_data[CTRL_IN_INV];
                end
                ADDR_SRC: begin
                    st_d.cfg.out_src = wr_data[SRC_OUT_LSB +: SRC_W];
                    st_d.cfg.in_src  = wr_data[SRC_IN_LSB +: SRC_W];
                end
                default: ;
            endcase
        end
        if (fire[PATH_OUT]) begin
            st_d.out_lat = st_q.hold;
        end
        if (fire[PATH_IN]) begin
            st_d.in_lat = pin_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        out_val = clocked[PATH_OUT] ? st_q.out_lat : st_q.hold;
        in_val  = clocked[PATH_IN]  ? st_q.in_lat  : pin_s;
        pin_oe  = st_q.cfg.drive | dir_s;
        pin_out = out_val;
        rd_data = pin_oe ? out_val : in_val;
    end

    AST_DRIVE_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[CTRL_DRIVE]) |=> pin_oe); // R2

    AST_TRANSPARENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DATA && !clocked[PATH_OUT]) |=> (pin_out == $past(wr_data))); // R4

    AST_CLOCKED_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clocked[PATH_OUT] && !fire[PATH_OUT]) |=>
        ((pin_out == $past(pin_out)) || (st_q.cfg.out_src != $past(st_q.cfg.out_src)))); // R5

    AST_IMM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig && !$past(sw_trig) && st_q.cfg.out_src == SRC_IMM
         && $past(st_q.cfg.out_src) == SRC_IMM && !st_q.cfg.out_inv
         && !$past(st_q.cfg.out_inv) && !(wr_en && wr_addr == ADDR_SRC))
        |=> (pin_out == $past(st_q.hold))); // R6

endmodule

// File: tb/clkd_byte_port_bench.sv
module clkd_byte_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ext_clk = 1'b0;
    logic       trig_in = 1'b0;
    logic       glb_trig = 1'b0;
    logic       sw_trig = 1'b0;
    logic       dir_req = 1'b0;
    logic [7:0] pin_in = 8'd0;
    logic [7:0] pin_out;
    logic       pin_oe;
    logic [7:0] rd_data;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    clkd_byte_port u_clkd_byte_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ext_clk  (ext_clk),
        .trig_in  (trig_in),
        .glb_trig (glb_trig),
        .sw_trig  (sw_trig),
        .dir_req  (dir_req),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .rd_data  (rd_data)
    );

    always #2 clk = ~clk;

    // {kind (0 host write / 1 pin value), stimulus, expected}
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h5C, 8'h5C},
        {1'b0, 8'hFF, 8'hFF},
        {1'b0, 8'h01, 8'h01},
        {1'b0, 8'h80, 8'h80},
        {1'b1, 8'hA3, 8'hA3},
        {1'b1, 8'h00, 8'h00},
        {1'b1, 8'h7F, 8'h7F},
        {1'b1, 8'h96, 8'h96}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic       drv;
        logic [7:0] prev;
        @(negedge clk);
        // R1 reset state
        ticks(3);
        chk("R1 oe in reset", {7'd0, pin_oe}, 8'd0);
        chk("R1 pin_out in reset", pin_out, 8'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 oe after reset", {7'd0, pin_oe}, 8'd0);
        chk("R1 pin_out after reset", pin_out, 8'd0);
        chk("R1 rd after reset", rd_data, 8'd0);

        // R2 drive bit
        host_wr(2'd1, 8'h01);
        chk("R2 drive on", {7'd0, pin_oe}, 8'd1);
        host_wr(2'd1, 8'h00);
        chk("R2 drive off", {7'd0, pin_oe}, 8'd0);

        // R3 external direction request
        dir_req = 1'b1;
        tick();
        chk("R3 dir not yet", {7'd0, pin_oe}, 8'd0);
        tick();
        chk("R3 dir applied", {7'd0, pin_oe}, 8'd1);
        dir_req = 1'b0;
        ticks(2);
        chk("R3 dir released", {7'd0, pin_oe}, 8'd0);

        // Table: transparent output and input
        drv = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            if (!VEC[i][16]) begin
                if (!drv) host_wr(2'd1, 8'h01);
                drv = 1'b1;
                host_wr(2'd0, VEC[i][15:8]);
                chk("R4 transparent out", pin_out, VEC[i][7:0]);
                chk("R10 rd when driving", rd_data, VEC[i][7:0]);
            end else begin
                if (drv) host_wr(2'd1, 8'h00);
                drv  = 1'b0;
                prev = rd_data;
                pin_in = VEC[i][15:8];
                tick();
                chk("R8 input latency", rd_data, prev);
                tick();
                chk("R8 transparent in", rd_data, VEC[i][7:0]);
            end
        end

        // R5 / R11 / R12 trigger-input clocking
        host_wr(2'd1, 8'h01);
        host_wr(2'd2, 8'h22);
        chk("R5 clocked shows latch", pin_out, 8'h00);
        host_wr(2'd0, 8'hA5);
        chk("R5 write held back", pin_out, 8'h00);
        glb_trig = 1'b1;
        ticks(4);
        glb_trig = 1'b0;
        ticks(3);
        sw_trig = 1'b1;
        tick();
        sw_trig = 1'b0;
        tick();
        chk("R11 unselected no capture", pin_out, 8'h00);
        trig_in = 1'b1;
        ticks(2);
        chk("R12 before third edge", pin_out, 8'h00);
        tick();
        chk("R12 third edge capture", pin_out, 8'hA5);
        chk("R10 rd shows latch", rd_data, 8'hA5);
        host_wr(2'd0, 8'h5A);
        ticks(3);
        chk("R5 no edge no change", pin_out, 8'hA5);
        trig_in = 1'b0;
        ticks(3);

        // R6 immediate pulse into both latches
        host_wr(2'd2, 8'h44);
        pin_in = 8'h3C;
        ticks(2);
        host_wr(2'd0, 8'h6B);
        chk("R5 imm before pulse", pin_out, 8'hA5);
        sw_trig = 1'b1;
        tick();
        sw_trig = 1'b0;
        chk("R6 out capture", pin_out, 8'h6B);
        chk("R10 rd driving", rd_data, 8'h6B);
        host_wr(2'd1, 8'h00);
        chk("R6 in capture", rd_data, 8'h3C);
        pin_in = 8'h81;
        ticks(4);
        chk("R9 in latch holds", rd_data, 8'h3C);

        // R7 polarity flip over a low front-panel clock
        host_wr(2'd2, 8'h11);
        host_wr(2'd0, 8'hC3);
        host_wr(2'd1, 8'h01);
        chk("R7 before flip", pin_out, 8'h6B);
        host_wr(2'd1, 8'h03);
        chk("R7 flip not yet", pin_out, 8'h6B);
        tick();
        chk("R7 flip captured", pin_out, 8'hC3);
        host_wr(2'd1, 8'h02);
        chk("R7 input untouched", rd_data, 8'h3C);
        host_wr(2'd1, 8'h06);
        chk("R7 in flip not yet", rd_data, 8'h3C);
        tick();
        chk("R7 in flip captured", rd_data, 8'h81);

        // R7 / R12 inverted front-panel clock captures on its fall
        host_wr(2'd0, 8'h99);
        ext_clk = 1'b1;
        pin_in  = 8'h7E;
        ticks(4);
        chk("R7 inverted rise no capture", pin_out, 8'hC3);
        chk("R9 in holds on inverted rise", rd_data, 8'h81);
        ext_clk = 1'b0;
        ticks(2);
        chk("R12 fall before third edge", pin_out, 8'hC3);
        tick();
        chk("R12 fall out capture", pin_out, 8'h99);
        chk("R12 fall in capture", rd_data, 8'h7E);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule